// File: doc/BRIEF.md
# Radio Transceiver Boot Sequencer

This block takes an external radio transceiver that is controlled over SPI from power-on to a configured low-power state with no processor involved. After a start request it drives the transceiver's select, clock and data pins directly to produce a manual reset pulse. It then waits for the device to report ready on its data-out line and sends a software-reset command. After that it performs a series of SPI transactions through a byte-level transfer engine: a burst write of the whole configuration image, a single write to the power-amplifier table, and two command strobes that put the part first into idle and then into power-down.

The sequencer owns the chip select for the whole run. It owns the serial clock and data-out lines only during the manual reset phase, and it marks that window with a pin-ownership output. While that output is low, a separate transfer engine sends the bytes. The sequencer hands the engine one byte at a time and holds the byte until the engine acknowledges it. Before any transaction, whenever the device must show ready, the sequencer polls the data-out line under a timeout. The run ends in a held done state or, if the timeout expires, in a held error state. A new start request leaves either state.

Top module: `radio_boot_seq`

## Requirements
- R1: After reset cs_n_o is 1 and pin_own_o, done_o, err_o and xfer_req_o are 0.
- R2: A start request makes the block take the pins (pin_own_o=1) with cs_n_o=0, sck_o=1 and mosi_o=0 for exactly DLY_CYC cycles.
- R3: Next, cs_n_o is 1 with sck_o=1 for exactly DLY_CYC cycles. Then cs_n_o returns to 0 with sck_o=0 while the block still owns the pins.
- R4: While miso_i stays high after that re-select, no byte is requested. Once miso_i is low, the first frame is the single byte 0x30 (software reset).
- R5: After the reset byte is acknowledged, cs_n_o stays 0 and no byte is requested until miso_i is low. Only then does cs_n_o rise.
- R6: The second frame is the header 0x40 (start address 0, burst flag in bit 6), followed by IMG_LEN image bytes. Image byte i equals ((29*i) mod 256) XOR 0xA5.
- R7: The third frame is the two bytes 0x3E, 0xC0 (power-amplifier table write).
- R8: The fourth frame is the single byte 0x36 (idle) and the fifth is the single byte 0x39 (power-down). Each frame opens with a miso_i ready-poll under cs_n_o=0.
- R9: After the last frame done_o goes to 1 and stays 1 until a start request. A start request in the done state clears done_o and runs the whole sequence again.
- R10: If any ready-poll sees miso_i high for WAIT_MAX cycles, err_o goes to 1 with cs_n_o=1. No further byte is requested, and this state holds until a start request.
- R11: A start request during a run has no effect on the run: the byte stream and the done result are unchanged.
- R12: xfer_req_o is 1 only while cs_n_o=0 and pin_own_o=0. A requested byte stays stable until xfer_ack_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request (sampled each cycle) |
| miso_i | input | 1 | Transceiver data-out line, low means ready |
| cs_n_o | output | 1 | Chip select, active low |
| pin_own_o | output | 1 | Sequencer drives sck_o/mosi_o (manual reset phase) |
| sck_o | output | 1 | Serial clock level while pin_own_o=1 |
| mosi_o | output | 1 | Serial data level while pin_own_o=1 |
| xfer_req_o | output | 1 | Byte transfer request to the SPI engine |
| xfer_byte_o | output | 8 | Byte to send |
| xfer_ack_i | input | 1 | Engine has sent the requested byte (one-cycle pulse) |
| done_o | output | 1 | Sequence completed |
| err_o | output | 1 | Ready-poll timeout occurred |

## Verification
The hardest case to reach from the ports is the second ready-poll, the one that follows the reset byte. It lasts only while miso_i is high right after that byte is acknowledged, and a responsive device skips it entirely. The bench's transfer-engine model raises miso_i in the same cycle in which it acknowledges the first byte. It holds miso_i there for several cycles and checks that chip select stays low and no byte is requested. The first poll is stretched the same way by holding miso_i high through the manual reset. The timeout case keeps miso_i high for the whole run.

// File: rtl/radio_boot_pkg.sv
package radio_boot_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PWR, ST_CSHI, ST_SYNC, ST_SEL,
    ST_SEND, ST_RWAIT, ST_GAP, ST_DONE, ST_ERR
  } boot_st_e;

  localparam logic [7:0] CMD_RESET  = 8'h30;
  localparam logic [7:0] CMD_IDLE   = 8'h36;
  localparam logic [7:0] CMD_SLEEP  = 8'h39;
  localparam logic [7:0] ADR_PATAB  = 8'h3E;
  localparam logic [7:0] PA_VALUE   = 8'hC0;
  localparam logic [7:0] BURST_HDR  = 8'h40;
  localparam int         NUM_TXN    = 5;

  // configuration image content, index i
  function automatic logic [7:0] img_byte(input int unsigned i);
    logic [31:0] prod;
    prod = i * 32'd29;
    return prod[7:0] ^ 8'hA5;
  endfunction

  // bytes in transaction t (header included)
  function automatic int unsigned txn_len(input logic [2:0] t, input int unsigned img_len);
    case (t)
      3'd1:    return img_len + 1;
      3'd2:    return 2;
      default: return 1;
    endcase
  endfunction

  // header byte of transaction t
  function automatic logic [7:0] txn_hdr(input logic [2:0] t);
    case (t)
      3'd0:    return CMD_RESET;
      3'd1:    return BURST_HDR;
      3'd2:    return ADR_PATAB;
      3'd3:    return CMD_IDLE;
      default: return CMD_SLEEP;
    endcase
  endfunction

endpackage

// File: rtl/boot_timer.sv
module boot_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CMAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_o <= '0;
    else if (restart)       cnt_o <= '0;
    else if (cnt_o != CMAX) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/cfg_rom.sv
module cfg_rom
  import radio_boot_pkg::*;
#(
  parameter int IMG_LEN = 41,
  parameter int AW      = 6
) (
  input  logic [AW-1:0] addr,
  output logic [7:0]    data
);
  logic [7:0] rom [IMG_LEN];

  for (genvar g = 0; g < IMG_LEN; g++) begin : g_rom
    assign rom[g] = img_byte(g);
  end

  always_comb begin
    data = '0;
    for (int k = 0; k < IMG_LEN; k++)
      if (addr == AW'(k)) data = rom[k];
  end
endmodule

// File: rtl/boot_step_rom.sv
module boot_step_rom
  import radio_boot_pkg::*;
#(
  parameter int IMG_LEN = 41,
  parameter int PW      = 6
) (
  input  logic [2:0]    txn,
  input  logic [PW-1:0] pos,
  output logic [7:0]    byte_o,
  output logic          last_o
);
  logic [7:0]    img_q;
  logic [PW-1:0] img_addr;

  assign img_addr = pos - 1'b1;

  cfg_rom #(.IMG_LEN(IMG_LEN), .AW(PW)) u_rom (
    .addr (img_addr),
    .data (img_q)
  );

  always_comb begin
    if (pos == '0)         byte_o = txn_hdr(txn);
    else if (txn == 3'd1)  byte_o = img_q;
    else                   byte_o = PA_VALUE;
    last_o = (pos == PW'(txn_len(txn, IMG_LEN) - 1));
  end
endmodule

// File: rtl/radio_boot_seq.sv
module radio_boot_seq
  import radio_boot_pkg::*;
#(
  parameter int DLY_CYC  = 512,
  parameter int WAIT_MAX = 4096,
  parameter int IMG_LEN  = 41
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       miso_i,
  output logic       cs_n_o,
  output logic       pin_own_o,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       xfer_req_o,
  output logic [7:0] xfer_byte_o,
  input  logic       xfer_ack_i,
  output logic       done_o,
  output logic       err_o
);
  localparam int CW = $clog2(((DLY_CYC > WAIT_MAX) ? DLY_CYC : WAIT_MAX) + 1);
  localparam int PW = $clog2(IMG_LEN + 2);

  boot_st_e      state_q, state_d;
  logic [CW-1:0] cnt;
  logic [2:0]    txn_q;
  logic [PW-1:0] pos_q;
  logic          step_last;
  logic          dly_hit, to_hit, polling, tmo_evt, byte_evt;

  boot_timer #(.CW(CW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (state_q != state_d),
    .cnt_o   (cnt)
  );

  boot_step_rom #(.IMG_LEN(IMG_LEN), .PW(PW)) u_step (
    .txn    (txn_q),
    .pos    (pos_q),
    .byte_o (xfer_byte_o),
    .last_o (step_last)
  );

  assign dly_hit  = (cnt == CW'(DLY_CYC - 1));
  assign to_hit   = (cnt == CW'(WAIT_MAX - 1));
  assign polling  = (state_q == ST_SYNC) || (state_q == ST_SEL) || (state_q == ST_RWAIT);
  assign tmo_evt  = polling && miso_i && to_hit;
  assign byte_evt = (state_q == ST_SEND) && xfer_ack_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_DONE, ST_ERR: if (start_i) state_d = ST_PWR;
      ST_PWR:   if (dly_hit) state_d = ST_CSHI;
      ST_CSHI:  if (dly_hit) state_d = ST_SYNC;
      ST_SYNC, ST_SEL: begin
        if (!miso_i)     state_d = ST_SEND;
        else if (to_hit) state_d = ST_ERR;
      end
      ST_SEND:  if (xfer_ack_i && step_last) state_d = (txn_q == 3'd0) ? ST_RWAIT : ST_GAP;
      ST_RWAIT: begin
        if (!miso_i)     state_d = ST_GAP;
        else if (to_hit) state_d = ST_ERR;
      end
      ST_GAP:   state_d = (txn_q == 3'(NUM_TXN - 1)) ? ST_DONE : ST_SEL;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      txn_q   <= '0;
      pos_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d == ST_PWR) begin
        txn_q <= '0;
        pos_q <= '0;
      end else if (byte_evt) begin
        pos_q <= step_last ? '0 : pos_q + 1'b1;
      end else if (state_q == ST_GAP && state_d == ST_SEL) begin
        txn_q <= txn_q + 1'b1;
      end
    end
  end

  always_comb begin
    cs_n_o    = 1'b1;
    pin_own_o = 1'b0;
    sck_o     = 1'b0;
    mosi_o    = 1'b0;
    case (state_q)
      ST_PWR:  begin cs_n_o = 1'b0; pin_own_o = 1'b1; sck_o = 1'b1; end
      ST_CSHI: begin cs_n_o = 1'b1; pin_own_o = 1'b1; sck_o = 1'b1; end
      ST_SYNC: begin cs_n_o = 1'b0; pin_own_o = 1'b1; end
      ST_SEL, ST_SEND, ST_RWAIT: cs_n_o = 1'b0;
      default: ;
    endcase
  end

  assign xfer_req_o = (state_q == ST_SEND);
  assign done_o     = (state_q == ST_DONE);
  assign err_o      = (state_q == ST_ERR);
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       cs_n_o,
  input logic       pin_own_o,
  input logic       xfer_req_o,
  input logic [7:0] xfer_byte_o,
  input logic       xfer_ack_i,
  input logic       done_o,
  input logic       err_o,
  input logic       tmo_evt
);
  // R12
  req_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req_o |-> (!cs_n_o && !pin_own_o));

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req_o && !xfer_ack_i) |=> (xfer_req_o && $stable(xfer_byte_o)));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !start_i) |=> err_o);

  // R10
  tmo_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> (err_o && cs_n_o));

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!xfer_req_o && !done_o));
endmodule

bind radio_boot_seq boot_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .cs_n_o      (cs_n_o),
  .pin_own_o   (pin_own_o),
  .xfer_req_o  (xfer_req_o),
  .xfer_byte_o (xfer_byte_o),
  .xfer_ack_i  (xfer_ack_i),
  .done_o      (done_o),
  .err_o       (err_o),
  .tmo_evt     (tmo_evt)
);

// File: tb/sim_radio_boot_seq.sv
`timescale 1ns/1ps
module sim_radio_boot_seq;
  localparam int DLY = 16;
  localparam int WTO = 64;
  localparam int IMG = 41;

  // frame, header, length
  localparam logic [7:0] FRM [5][3] = '{
    '{8'd1, 8'h30, 8'd1},
    '{8'd2, 8'h40, 8'd42},
    '{8'd3, 8'h3E, 8'd2},
    '{8'd4, 8'h36, 8'd1},
    '{8'd5, 8'h39, 8'd1}
  };

  logic clk = 0, rst_n = 0, start = 0, miso = 0, ack = 0;
  logic cs_n, own, sck, mosi, req, done, err;
  logic [7:0] xbyte;

  int n_chk = 0, n_bad = 0;
  logic [7:0] log_b [64];
  int log_f [64];
  int nlog = 0, frames = 0, dcnt = 0;
  logic prev_cs = 1;
  logic hold_rst = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  radio_boot_seq #(.DLY_CYC(DLY), .WAIT_MAX(WTO), .IMG_LEN(IMG)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .miso_i(miso),
    .cs_n_o(cs_n), .pin_own_o(own), .sck_o(sck), .mosi_o(mosi),
    .xfer_req_o(req), .xfer_byte_o(xfer_byte_alias), .xfer_ack_i(ack),
    .done_o(done), .err_o(err)
  );
  logic [7:0] xfer_byte_alias;
  assign xbyte = xfer_byte_alias;

  // transfer engine model
  always @(negedge clk) begin
    if (cs_n && !prev_cs) frames = frames + 1;
    prev_cs = cs_n;
    if (ack) ack = 0;
    else if (req) begin
      if (dcnt == 2) begin
        ack = 1; dcnt = 0;
        if (nlog < 64) begin log_b[nlog] = xbyte; log_f[nlog] = frames; end
        nlog = nlog + 1;
        if (hold_rst && nlog == 1) miso = 1;
      end else dcnt = dcnt + 1;
    end
  end

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic clear_log();
    nlog = 0; frames = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_end(input int lim);
    for (int i = 0; i < lim && !done && !err; i++) @(negedge clk);
  endtask

  task automatic check_stream(input string tag);
    int idx = 0;
    logic [7:0] acc = 0;
    check(nlog == 47, tag, nlog, 47);
    for (int f = 0; f < 5; f++) begin
      for (int k = 0; k < int'(FRM[f][2]); k++) begin
        logic [7:0] e;
        string t;
        if (k == 0) e = FRM[f][1];
        else if (f == 1) begin e = acc ^ 8'hA5; acc = acc + 8'd29; end
        else e = 8'hC0;
        t = (f == 0) ? "R4" : (f == 1) ? "R6" : (f == 2) ? "R7" : "R8";
        if (idx < nlog && idx < 64) begin
          check(log_b[idx] == e, {tag, " ", t}, log_b[idx], e);
          check(log_f[idx] == int'(FRM[f][0]), {tag, " ", t, " frame"}, log_f[idx], FRM[f][0]);
        end
        idx++;
      end
    end
  endtask

  initial begin
    #400000;
    check(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    int pwr, hi;
    bit sync_ok, req_seen;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(cs_n == 1 && own == 0 && done == 0 && err == 0 && req == 0, "R1", {cs_n, own, done, err, req}, 5'b10000);
    rst_n = 1;

    // Test A: nominal run, walk the frame table
    clear_log();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    pwr = 0; hi = 0; sync_ok = 0;
    for (int i = 0; i < 3000 && !done && !err; i++) begin
      if (own && !cs_n && sck && !mosi) pwr++;
      if (own && cs_n && sck) hi++;
      if (own && !cs_n && !sck) sync_ok = 1;
      @(negedge clk);
    end
    check(pwr == DLY, "R2", pwr, DLY);
    check(hi == DLY, "R3", hi, DLY);
    check(sync_ok || nlog > 0, "R3 reselect", sync_ok, 1);
    check(done == 1 && err == 0, "R9 done", {done, err}, 2'b10);
    check_stream("A");
    // R9 done held
    repeat (20) @(negedge clk);
    check(done == 1 && cs_n == 1, "R9 hold", {done, cs_n}, 2'b11);

    // Test B: stretched ready-polls, restart from done
    clear_log();
    miso = 1; hold_rst = 1;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(done == 0, "R9 clear", done, 0);
    for (int i = 0; i < 200 && !(own && !cs_n && !sck); i++) @(negedge clk);
    req_seen = 0;
    for (int i = 0; i < 10; i++) begin
      if (req) req_seen = 1;
      @(negedge clk);
    end
    check(!req_seen && nlog == 0, "R4 poll", nlog, 0);
    miso = 0;
    for (int i = 0; i < 100 && nlog == 0; i++) @(negedge clk);
    req_seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (req || cs_n) req_seen = 1;
    end
    check(!req_seen && nlog == 1, "R5 hold", {req_seen, 8'(nlog)}, 1);
    hold_rst = 0; miso = 0;
    wait_end(3000);
    check(done == 1, "R5 done", done, 1);
    check_stream("B");

    // Test C: start during a run is ignored
    clear_log();
    pulse_start();
    repeat (5) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    repeat (60) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    wait_end(3000);
    check(done == 1 && nlog == 47, "R11", nlog, 47);

    // Test D: timeout
    clear_log();
    miso = 1;
    pulse_start();
    wait_end(500);
    check(err == 1 && done == 0 && cs_n == 1, "R10 err", {err, done, cs_n}, 3'b101);
    check(nlog == 0, "R10 bytes", nlog, 0);
    repeat (30) @(negedge clk);
    check(err == 1 && req == 0 && nlog == 0, "R10 hold", {err, req}, 2'b10);
    // recovery from error
    miso = 0; clear_log();
    pulse_start();
    check(err == 0, "R10 leave", err, 0);
    wait_end(3000);
    check(done == 1 && nlog == 47, "R9 rerun", nlog, 47);

    // mid-run reset returns to R1 state
    pulse_start();
    repeat (40) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check(cs_n == 1 && own == 0 && done == 0 && err == 0 && req == 0, "R1 midrun", {cs_n, own, done, err, req}, 5'b10000);
    rst_n = 1;
    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule